// File: doc/BRIEF.md
# DMA Block Transfer Sequencer

This block moves a block of words between system memory and a tape formatter, one word for each formatter request. Software first sets up a memory address and a word count. It then writes the control register, which picks the direction and arms the sequencer. Each time the formatter asks for a word, the block wins one bus cycle. In tape-write mode that cycle reads memory and latches the word toward the formatter. In tape-read mode it writes the formatter's word into memory.

After each bus cycle a three-stage one-hot timing chain runs. The chain is stepped by a slow timing tick. Its first stage lowers the count and advances the address in the same step. The second stage ends that step. The third stage is the end-of-cycle phase. When that phase ends, the block tests the count. If the count is not zero, the block re-arms for the next word. If it is zero, the block raises its completion flag instead. The next formatter request after completion is answered with an interrupt request and not with a bus cycle. A timing-error pulse from the formatter sets an error latch, stops further transfers and also raises the interrupt.

Top module: `dma_blk_seq`

## Requirements
- R1: A host write with `reg_sel`=0 (control) takes the direction from `reg_wdata[1]` (1 = memory to tape, 0 = tape to memory). It clears the completion flag, the error latch and the interrupt, returns the sequencer to idle and arms it. Status bit 0 (armed) reads 1, bit 1 mirrors the direction, and bits 5, 6 and 7 read 0.
- R2: Each request accepted while the block is armed produces exactly one bus cycle (`bus_req_o` high until `bus_gnt_i`). The cycle is at the current address register value, with `bus_we_o` = 1 in tape-to-memory mode and 0 in memory-to-tape mode.
- R3: In memory-to-tape mode, `bus_rdata_i` at the grant is latched onto `fmt_data_o`. In tape-to-memory mode, `fmt_data_i` at request acceptance is driven on `bus_wdata_o` for the bus cycle.
- R4: After each grant, the block runs three stages, each advanced by one `tick_i`. The count is decremented and the address incremented together as the first stage begins. The end of the sequence falls on the fourth tick after the grant. No request is accepted before then, even when `word_req_i` is held high.
- R5: At the end of the sequence, a zero count sets the completion flag (status bit 7) and leaves the block unarmed. A nonzero count re-arms the block instead, so the two never hold together.
- R6: A request that arrives while the completion flag is set raises `irq_o` (status bit 5) and starts no bus cycle.
- R7: A `tmerr_i` pulse sets the error latch (status bit 6) and raises `irq_o`. While the latch is set, no request starts a bus cycle.
- R8: Host writes to the address register (`reg_sel`=1) or the count register (`reg_sel`=2) are ignored while the sequencer is busy (status bit 3).
- R9: Status bit 4 reads 1 exactly when the address register holds all ones (address exhausted).
- R10: After reset the status word is zero, and `irq_o`, `bus_req_o` and `word_ack_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 count |
| reg_wdata | input | 16 | Host write data |
| status_o | output | 8 | Status word (bit 7 completion, 6 error, 5 interrupt, 4 address exhausted, 3 busy, 1 direction, 0 armed) |
| bus_req_o | output | 1 | Bus cycle request |
| bus_gnt_i | input | 1 | Bus cycle completes this clock |
| bus_we_o | output | 1 | Bus cycle writes memory |
| bus_addr_o | output | 16 | Memory address of the bus cycle |
| bus_rdata_i | input | 16 | Memory read data |
| bus_wdata_o | output | 16 | Memory write data |
| word_req_i | input | 1 | Formatter word request (level) |
| word_ack_o | output | 1 | Request consumed this clock |
| fmt_data_i | input | 16 | Word from the formatter |
| fmt_data_o | output | 16 | Word to the formatter |
| tmerr_i | input | 1 | Formatter timing error pulse |
| tick_i | input | 1 | Timing-chain step strobe |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The main path is swept over both directions, block lengths one to five and start addresses at zero, mid-range and just below the all-ones wrap. Different lengths show whether completion fires on the right word, not one early or late. The wrap start shows whether the exhausted flag and the address carry are correct. The formatter request is held high throughout, so the tick count between grant and the next bus request shows whether the chain holds requests off for its full length. Separate runs inject a timing error in mid-block and write the pointers during a busy sequence. These runs show whether the error latch and the busy lockout block what they should.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_BUS  = 2'd1,
    SQ_SEQ  = 2'd2
  } sq_state_t;

  // host register select codes
  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_LEN  = 2'd2;

  // control word field
  localparam int CTL_DIR_BIT = 1;

  // status word bit positions
  localparam int STW       = 8;
  localparam int ST_ARMED  = 0;
  localparam int ST_DIR    = 1;
  localparam int ST_BUSY   = 3;
  localparam int ST_AFULL  = 4;
  localparam int ST_IRQ    = 5;
  localparam int ST_ERR    = 6;
  localparam int ST_DONE   = 7;

endpackage

// File: rtl/dma_phase_chain.sv
module dma_phase_chain #(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic              tick,
  output logic              upd_o,
  output logic              eoc_end_o,
  output logic [STAGES-1:0] phase_o
);

  logic              pend_q, pend_d;
  logic [STAGES-1:0] stg_q, stg_d;
  logic [STAGES-1:0] shift_in;

  // each stage takes the one before it; stage 0 takes the pending token
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_link
      if (i == 0) begin : g_head
        assign shift_in[i] = pend_q;
      end else begin : g_body
        assign shift_in[i] = stg_q[i-1];
      end
    end
  endgenerate

  always_comb begin
    pend_d = pend_q;
    stg_d  = stg_q;
    if (clr) begin
      pend_d = 1'b0;
      stg_d  = '0;
    end else if (start) begin
      pend_d = 1'b1;
    end else if (tick) begin
      pend_d = 1'b0;
      stg_d  = shift_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      stg_q  <= '0;
    end else begin
      pend_q <= pend_d;
      stg_q  <= stg_d;
    end
  end

  assign upd_o     = tick & pend_q & ~clr & ~start;
  assign eoc_end_o = tick & stg_q[STAGES-1] & ~clr & ~start;
  assign phase_o   = stg_q;

endmodule

// File: rtl/dma_ptr_regs.sv
module dma_ptr_regs #(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic [AW-1:0] addr_wdata,
  input  logic          ld_len,
  input  logic [LW-1:0] len_wdata,
  input  logic          upd,
  input  logic          cap_fmt,
  input  logic [DW-1:0] fmt_data,
  input  logic          cap_bus,
  input  logic [DW-1:0] bus_data,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] len_o,
  output logic          len_zero_o,
  output logic          addr_full_o,
  output logic [DW-1:0] data_o
);

  localparam logic [AW-1:0] ADDR_STEP = AW'(1);
  localparam logic [LW-1:0] LEN_STEP  = LW'(1);

  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] len_q, len_d;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    addr_d = addr_q;
    len_d  = len_q;
    if (ld_addr) begin
      addr_d = addr_wdata;
    end else if (upd) begin
      addr_d = addr_q + ADDR_STEP;
    end
    if (ld_len) begin
      len_d = len_wdata;
    end else if (upd) begin
      len_d = len_q - LEN_STEP;
    end
  end

  always_comb begin
    data_d = data_q;
    if (cap_fmt) begin
      data_d = fmt_data;
    end else if (cap_bus) begin
      data_d = bus_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      data_q <= '0;
    end else begin
      addr_q <= addr_d;
      len_q  <= len_d;
      data_q <= data_d;
    end
  end

  assign addr_o      = addr_q;
  assign len_o       = len_q;
  assign len_zero_o  = (len_q == '0);
  assign addr_full_o = &addr_q;
  assign data_o      = data_q;

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_dir,
  input  logic word_req,
  input  logic bus_gnt,
  input  logic tmerr,
  input  logic eoc_end,
  input  logic len_zero,
  output logic busy_o,
  output logic armed_o,
  output logic done_o,
  output logic err_o,
  output logic irq_o,
  output logic dir_o,
  output logic bus_req_o,
  output logic word_ack_o,
  output logic seq_start_o,
  output logic cap_fmt_o,
  output logic cap_bus_o
);

  sq_state_t st_q, st_d;
  logic armed_q, armed_d;
  logic done_q, done_d;
  logic err_q, err_d;
  logic irq_q, irq_d;
  logic dir_q, dir_d;

  always_comb begin
    st_d        = st_q;
    armed_d     = armed_q;
    done_d      = done_q;
    err_d       = err_q;
    irq_d       = irq_q;
    dir_d       = dir_q;
    word_ack_o  = 1'b0;
    seq_start_o = 1'b0;
    cap_fmt_o   = 1'b0;
    cap_bus_o   = 1'b0;
    if (ctl_wr) begin
      dir_d   = ctl_dir;
      done_d  = 1'b0;
      err_d   = 1'b0;
      irq_d   = 1'b0;
      armed_d = 1'b1;
      st_d    = SQ_IDLE;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (word_req && armed_q && !err_q) begin
            st_d      = SQ_BUS;
            armed_d   = 1'b0;
            cap_fmt_o = ~dir_q;
          end else if (word_req && done_q && !irq_q) begin
            irq_d      = 1'b1;
            word_ack_o = 1'b1;
          end
        end
        SQ_BUS: begin
          if (bus_gnt) begin
            word_ack_o  = 1'b1;
            cap_bus_o   = dir_q;
            seq_start_o = 1'b1;
            st_d        = SQ_SEQ;
          end
        end
        SQ_SEQ: begin
          if (eoc_end) begin
            st_d = SQ_IDLE;
            if (len_zero) begin
              done_d = 1'b1;
            end else begin
              armed_d = 1'b1;
            end
          end
        end
        default: st_d = SQ_IDLE;
      endcase
      if (tmerr) begin
        err_d = 1'b1;
        irq_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
      done_q  <= done_d;
      err_q   <= err_d;
      irq_q   <= irq_d;
      dir_q   <= dir_d;
    end
  end

  assign busy_o    = (st_q != SQ_IDLE);
  assign bus_req_o = (st_q == SQ_BUS);
  assign armed_o   = armed_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign irq_o     = irq_q;
  assign dir_o     = dir_q;

endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq
  import dma_seq_pkg::*;
#(
  parameter int HW     = 16,
  parameter int AW     = 16,
  parameter int LW     = 16,
  parameter int DW     = 16,
  parameter int STAGES = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [1:0]     reg_sel,
  input  logic [HW-1:0]  reg_wdata,
  output logic [STW-1:0] status_o,
  output logic           bus_req_o,
  input  logic           bus_gnt_i,
  output logic           bus_we_o,
  output logic [AW-1:0]  bus_addr_o,
  input  logic [DW-1:0]  bus_rdata_i,
  output logic [DW-1:0]  bus_wdata_o,
  input  logic           word_req_i,
  output logic           word_ack_o,
  input  logic [DW-1:0]  fmt_data_i,
  output logic [DW-1:0]  fmt_data_o,
  input  logic           tmerr_i,
  input  logic           tick_i,
  output logic           irq_o
);

  logic              ctl_wr, ld_addr, ld_len;
  logic              busy_w, armed_w, done_w, err_w, irq_w, dir_w;
  logic              seq_start_w, cap_fmt_w, cap_bus_w;
  logic              upd_w, eoc_w, len_zero_w, addr_full_w;
  logic [STAGES-1:0] phase_w;
  logic [AW-1:0]     addr_w;
  logic [LW-1:0]     len_w;
  logic [DW-1:0]     data_w;

  assign ctl_wr  = reg_we & (reg_sel == SEL_CTL);
  assign ld_addr = reg_we & (reg_sel == SEL_ADDR) & ~busy_w;
  assign ld_len  = reg_we & (reg_sel == SEL_LEN) & ~busy_w;

  dma_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_dir     (reg_wdata[CTL_DIR_BIT]),
    .word_req    (word_req_i),
    .bus_gnt     (bus_gnt_i),
    .tmerr       (tmerr_i),
    .eoc_end     (eoc_w),
    .len_zero    (len_zero_w),
    .busy_o      (busy_w),
    .armed_o     (armed_w),
    .done_o      (done_w),
    .err_o       (err_w),
    .irq_o       (irq_w),
    .dir_o       (dir_w),
    .bus_req_o   (bus_req_o),
    .word_ack_o  (word_ack_o),
    .seq_start_o (seq_start_w),
    .cap_fmt_o   (cap_fmt_w),
    .cap_bus_o   (cap_bus_w)
  );

  dma_phase_chain #(.STAGES(STAGES)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ctl_wr),
    .start     (seq_start_w),
    .tick      (tick_i),
    .upd_o     (upd_w),
    .eoc_end_o (eoc_w),
    .phase_o   (phase_w)
  );

  dma_ptr_regs #(.AW(AW), .LW(LW), .DW(DW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_addr     (ld_addr),
    .addr_wdata  (reg_wdata[AW-1:0]),
    .ld_len      (ld_len),
    .len_wdata   (reg_wdata[LW-1:0]),
    .upd         (upd_w),
    .cap_fmt     (cap_fmt_w),
    .fmt_data    (fmt_data_i),
    .cap_bus     (cap_bus_w),
    .bus_data    (bus_rdata_i),
    .addr_o      (addr_w),
    .len_o       (len_w),
    .len_zero_o  (len_zero_w),
    .addr_full_o (addr_full_w),
    .data_o      (data_w)
  );

  always_comb begin
    status_o           = '0;
    status_o[ST_ARMED] = armed_w;
    status_o[ST_DIR]   = dir_w;
    status_o[ST_BUSY]  = busy_w;
    status_o[ST_AFULL] = addr_full_w;
    status_o[ST_IRQ]   = irq_w;
    status_o[ST_ERR]   = err_w;
    status_o[ST_DONE]  = done_w;
  end

  assign bus_we_o    = bus_req_o & ~dir_w;
  assign bus_addr_o  = addr_w;
  assign bus_wdata_o = data_w;
  assign fmt_data_o  = data_w;
  assign irq_o       = irq_w;

endmodule

// File: rtl/dma_seq_checker.sv
module dma_seq_checker #(
  parameter int AW     = 16,
  parameter int LW     = 16,
  parameter int STAGES = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STAGES-1:0] phase,
  input logic              upd,
  input logic [LW-1:0]     len_q,
  input logic [AW-1:0]     addr_q,
  input logic              done,
  input logic              armed,
  input logic              err,
  input logic              irq,
  input logic              bus_req,
  input logic              busy,
  input logic              len_zero
);

  assert_onehot_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase));

  assert_step_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (len_q == $past(len_q) - LW'(1)) && (addr_q == $past(addr_q) + AW'(1)));

  assert_done_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && armed));

  assert_done_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(phase[STAGES-1]) && len_zero));

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (done || err));

  assert_err_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !bus_req) |=> !bus_req);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !upd) |=> ($stable(addr_q) && $stable(len_q)));

endmodule

bind dma_blk_seq dma_seq_checker #(.AW(AW), .LW(LW), .STAGES(STAGES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .phase    (phase_w),
  .upd      (upd_w),
  .len_q    (len_w),
  .addr_q   (addr_w),
  .done     (done_w),
  .armed    (armed_w),
  .err      (err_w),
  .irq      (irq_w),
  .bus_req  (bus_req_o),
  .busy     (busy_w),
  .len_zero (len_zero_w)
);

// File: tb/test_dma_blk_seq.sv
module test_dma_blk_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [7:0]  status_o;
  logic        bus_req_o, bus_we_o, word_ack_o, irq_o;
  logic        bus_gnt_i = 1'b0;
  logic [15:0] bus_addr_o, bus_wdata_o, fmt_data_o;
  logic [15:0] bus_rdata_i = 16'd0;
  logic [15:0] fmt_data_i = 16'd0;
  logic        word_req_i = 1'b0;
  logic        tmerr_i = 1'b0;
  logic        tick_i = 1'b0;

  int n_tot = 0;
  int n_bad = 0;
  int tcnt = 0;
  int tphase = 0;

  always #5 clk = ~clk;

  dma_blk_seq i_dma_blk_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .status_o(status_o), .bus_req_o(bus_req_o),
    .bus_gnt_i(bus_gnt_i), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_rdata_i(bus_rdata_i), .bus_wdata_o(bus_wdata_o),
    .word_req_i(word_req_i), .word_ack_o(word_ack_o), .fmt_data_i(fmt_data_i),
    .fmt_data_o(fmt_data_o), .tmerr_i(tmerr_i), .tick_i(tick_i), .irq_o(irq_o)
  );

  // timing strobe: one clock in four
  always @(negedge clk) begin
    tphase = (tphase + 1) % 4;
    tick_i = (tphase == 0);
  end

  always @(posedge clk) if (tick_i) tcnt++;

  task automatic check(input string tag, input int act, input int exp);
    n_tot++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat_w(input int k);
    return 16'hA500 ^ 16'(k * 37);
  endfunction

  function automatic logic [15:0] pat_r(input int k);
    return 16'h3C00 + 16'(k * 11);
  endfunction

  task automatic host_wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 16'd0;
  endtask

  task automatic wait_bus();
    int t = 0;
    while (!bus_req_o && t < 200) begin @(negedge clk); t++; end
  endtask

  task automatic grant(input logic [15:0] d);
    bus_rdata_i = d; bus_gnt_i = 1'b1;
    @(posedge clk); #1 tcnt = 0;
    @(negedge clk);
    bus_gnt_i = 1'b0; bus_rdata_i = 16'd0;
  endtask

  task automatic wait_event();
    int t = 0;
    while (!bus_req_o && !status_o[7] && t < 200) begin @(negedge clk); t++; end
  endtask

  task automatic run_block(input bit dir, input int start, input int n);
    int fin;
    host_wr(2'd1, 16'(start));
    host_wr(2'd2, 16'(n));
    host_wr(2'd0, dir ? 16'h0002 : 16'h0000);
    check("R1 armed bit0", int'(status_o[0]), 1);
    check("R1 direction bit1", int'(status_o[1]), int'(dir));
    check("R1 done bit7 cleared", int'(status_o[7]), 0);
    fmt_data_i = pat_r(0);
    word_req_i = 1'b1;
    for (int k = 0; k < n; k++) begin
      wait_bus();
      check("R2 bus request", int'(bus_req_o), 1);
      check("R2 bus address", int'(bus_addr_o), (start + k) & 16'hFFFF);
      check("R2 bus write enable", int'(bus_we_o), int'(!dir));
      if (!dir) check("R3 tape-to-memory data", int'(bus_wdata_o), int'(pat_r(k)));
      grant(pat_w(k));
      if (dir) check("R3 memory-to-tape data", int'(fmt_data_o), int'(pat_w(k)));
      fmt_data_i = pat_r(k + 1);
      wait_event();
      check("R4 ticks until sequence end", tcnt, 4);
      if (k < n - 1) begin
        check("R5 not done mid-block", int'(status_o[7]), 0);
      end else begin
        check("R5 done at zero count", int'(status_o[7]), 1);
        check("R5 not armed when done", int'(status_o[0]), 0);
      end
    end
    fin = (start + n) & 16'hFFFF;
    check("R9 address exhausted bit4", int'(status_o[4]), int'(fin == 16'hFFFF));
    @(negedge clk);
    check("R6 irq after request when done", int'(irq_o), 1);
    check("R6 irq status bit5", int'(status_o[5]), 1);
    check("R6 no bus cycle when done", int'(bus_req_o), 0);
    word_req_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int starts[3];
    int cnt;
    starts[0] = 16'h0000; starts[1] = 16'h7FFD; starts[2] = 16'hFFFE;
    repeat (3) @(negedge clk);
    check("R10 status in reset", int'(status_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 status after reset", int'(status_o), 0);
    check("R10 irq after reset", int'(irq_o), 0);
    check("R10 bus_req after reset", int'(bus_req_o), 0);
    check("R10 word_ack after reset", int'(word_ack_o), 0);

    // main sweep
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 3; s++)
        for (int n = 1; n <= 5; n++)
          run_block(d[0], starts[s], n);

    // busy lockout of pointer writes
    host_wr(2'd1, 16'h0040);
    host_wr(2'd2, 16'd3);
    host_wr(2'd0, 16'h0000);
    word_req_i = 1'b1;
    wait_bus();
    grant(16'h0);
    check("R8 busy during sequence", int'(status_o[3]), 1);
    host_wr(2'd1, 16'h1234);
    host_wr(2'd2, 16'h0001);
    wait_bus();
    check("R8 address write ignored while busy", int'(bus_addr_o), 16'h0041);
    grant(16'h0);
    wait_event();
    check("R8 count write ignored while busy", int'(bus_req_o), 1);
    word_req_i = 1'b0;
    host_wr(2'd0, 16'h0000);

    // timing error
    host_wr(2'd1, 16'h0100);
    host_wr(2'd2, 16'd5);
    host_wr(2'd0, 16'h0002);
    word_req_i = 1'b1;
    wait_bus();
    grant(16'h0);
    tmerr_i = 1'b1;
    @(negedge clk);
    tmerr_i = 1'b0;
    check("R7 error bit6", int'(status_o[6]), 1);
    check("R7 irq on error", int'(irq_o), 1);
    cnt = 0;
    repeat (60) begin
      @(negedge clk);
      if (bus_req_o) cnt++;
    end
    check("R7 no bus cycles after error", cnt, 0);
    word_req_i = 1'b0;
    host_wr(2'd0, 16'h0000);
    check("R1 error cleared by control write", int'(status_o[6]), 0);
    check("R1 irq cleared by control write", int'(irq_o), 0);

    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tot++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

endmodule